// File: doc/BRIEF.md
# Configurable Pad I/O Cell

This block sits between one bidirectional package pin and the internal logic of a programmable fabric. Static configuration inputs pick how the cell behaves. It can pass the pin straight through to the fabric. It can capture the pin in a flip-flop or in a transparent latch clocked from one of the dedicated I/O clock lines. It can drive the pin as a pure output, or run as a bidirectional pin whose three-state driver is gated by a chosen enable.

The pin is modelled as three lines: the value seen on the pad, the value to drive, and the driver enable. The driven value passes through a polarity stage, so the fabric can work in active-high terms while the pin is active-low. The driver enable comes either from the cell's own enable input or from one of the global output-enable lines shared across the device. A single asynchronous active-low reset clears the capture storage.

Top module: `pio_cell`

## Requirements
- R1: Mode code 0 (combinational input) makes `core_din_o` follow `pad_in_i` with no clock involved.
- R2: Mode code 1 (registered input) makes `core_din_o` equal the value `pad_in_i` had at the most recent rising edge of the selected I/O clock, and it holds between edges.
- R3: Mode code 2 (latched input) makes `core_din_o` follow `pad_in_i` while the selected I/O clock is high, and hold the last value while that clock is low.
- R4: `cfg_clk_sel_i` value k selects `ioclk_i[k]` as the clock for both the input register and the latch.
- R5: In mode codes 0, 1 and 2, and in the unused codes 5 to 7, `pad_oe_o` is 0. The unused codes deliver the pin to the fabric in the same way as code 0.
- R6: Mode code 3 (output) delivers 0 on `core_din_o`. It drives `pad_oe_o` high when the enable source is the cell's own enable. Otherwise `pad_oe_o` equals the selected global enable.
- R7: Mode code 4 (bidirectional) sets `pad_oe_o` to the selected enable source, and `core_din_o` follows `pad_in_i` at all times.
- R8: `pad_out_o` equals `core_dout_i` when `cfg_inv_i` is 0, and its inverse when `cfg_inv_i` is 1, in every mode.
- R9: `cfg_oe_src_i` value 0 selects `core_oe_i`, value k in 1..2 selects `goe_i[k-1]`, and value 3 falls back to `core_oe_i`.
- R10: While `rst_ni` is low, the input register and the latch hold 0, so modes 1 and 2 deliver 0 whatever the pin carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset of register and latch |
| ioclk_i | input | 2 | Dedicated I/O clock lines |
| cfg_mode_i | input | 3 | Static mode code |
| cfg_inv_i | input | 1 | 1 inverts the driven pin value (active-low output) |
| cfg_clk_sel_i | input | 1 | Index of the I/O clock used for capture |
| cfg_oe_src_i | input | 2 | Driver enable source select |
| pad_in_i | input | 1 | Value present on the pin |
| pad_out_o | output | 1 | Value to drive onto the pin |
| pad_oe_o | output | 1 | Pin driver enable, 0 means high impedance |
| core_dout_i | input | 1 | Output data from the fabric |
| core_oe_i | input | 1 | Per-cell driver enable from the fabric |
| goe_i | input | 2 | Global output-enable lines |
| core_din_o | output | 1 | Input value delivered to the fabric |

## Verification
The assertions assume that the configuration inputs are quasi-static. They also assume that neither the configuration inputs nor the pin value change on an edge of either I/O clock. The capture checks compare the register against the pin value sampled at the previous edge, and the latch against the pin at the falling edge, so a pin change that coincides with an edge would make the expected value ambiguous. The stimulus changes every input two time units after a rising edge of the first I/O clock. Because the two clocks run in opposite phase, that instant lies away from every edge of both clocks. Each vector is then sampled one time unit later, before the next edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef logic [2:0] pio_mode_t;

  localparam pio_mode_t MODE_IN_COMB = 3'd0;
  localparam pio_mode_t MODE_IN_REG  = 3'd1;
  localparam pio_mode_t MODE_IN_LAT  = 3'd2;
  localparam pio_mode_t MODE_OUT     = 3'd3;
  localparam pio_mode_t MODE_BIDIR   = 3'd4;

  function automatic logic mode_drives(pio_mode_t m);
    return (m == MODE_OUT) || (m == MODE_BIDIR);
  endfunction
endpackage

// File: rtl/pio_in_path.sv
module pio_in_path import pio_pkg::*; #(
  parameter int unsigned NUM_CLK   = 2,
  parameter int unsigned CLK_SEL_W = 1
) (
  input  logic                 rst_ni,
  input  logic [NUM_CLK-1:0]   ioclk_i,
  input  logic [CLK_SEL_W-1:0] clk_sel_i,
  input  pio_mode_t            mode_i,
  input  logic                 pad_in_i,
  output logic                 din_o
);
  logic [NUM_CLK-1:0] reg_vec;
  logic [NUM_CLK-1:0] lat_vec;

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_clk
    logic reg_bit;
    logic lat_bit;

    always_ff @(posedge ioclk_i[k] or negedge rst_ni) begin
      if (!rst_ni) reg_bit <= 1'b0;
      else         reg_bit <= pad_in_i;
    end

    // transparent while clock high, closes on falling edge
    always_latch begin
      if (!rst_ni)         lat_bit = 1'b0;
      else if (ioclk_i[k]) lat_bit = pad_in_i;
    end

    assign reg_vec[k] = reg_bit;
    assign lat_vec[k] = lat_bit;

    a_r2_reg_captures_edge: assert property (@(posedge ioclk_i[k]) disable iff (!rst_ni)
      1'b1 |=> reg_bit == $past(pad_in_i));

    a_r3_latch_open_high: assert property (@(negedge ioclk_i[k]) disable iff (!rst_ni)
      1'b1 |-> lat_bit == pad_in_i);
  end

  logic sel_reg, sel_lat;

  // R4: clock line selection
  always_comb begin
    sel_reg = reg_vec[0];
    sel_lat = lat_vec[0];
    for (int k = 0; k < NUM_CLK; k++) begin
      if (clk_sel_i == CLK_SEL_W'(k)) begin
        sel_reg = reg_vec[k];
        sel_lat = lat_vec[k];
      end
    end
  end

  always_comb begin
    case (mode_i)
      MODE_IN_REG: din_o = sel_reg;
      MODE_IN_LAT: din_o = sel_lat;
      MODE_OUT:    din_o = 1'b0;
      default:     din_o = pad_in_i;
    endcase
  end
endmodule

// File: rtl/pio_out_path.sv
module pio_out_path import pio_pkg::*; #(
  parameter int unsigned NUM_GOE  = 2,
  parameter int unsigned OESRC_W  = 2
) (
  input  pio_mode_t            mode_i,
  input  logic                 inv_i,
  input  logic [OESRC_W-1:0]   oe_src_i,
  input  logic                 dout_i,
  input  logic                 core_oe_i,
  input  logic [NUM_GOE-1:0]   goe_i,
  output logic                 pad_out_o,
  output logic                 pad_oe_o
);
  logic sel_en;
  logic src_global;

  // source 0 and out-of-range codes use the per-cell enable
  always_comb begin
    sel_en     = core_oe_i;
    src_global = 1'b0;
    for (int k = 0; k < NUM_GOE; k++) begin
      if (oe_src_i == OESRC_W'(k + 1)) begin
        sel_en     = goe_i[k];
        src_global = 1'b1;
      end
    end
  end

  assign pad_out_o = dout_i ^ inv_i;

  always_comb begin
    case (mode_i)
      MODE_OUT:   pad_oe_o = src_global ? sel_en : 1'b1;
      MODE_BIDIR: pad_oe_o = sel_en;
      default:    pad_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pio_cell.sv
module pio_cell import pio_pkg::*; #(
  parameter  int unsigned NUM_IOCLK = 2,
  parameter  int unsigned NUM_GOE   = 2,
  localparam int unsigned CLK_SEL_W = (NUM_IOCLK > 1) ? $clog2(NUM_IOCLK) : 1,
  localparam int unsigned OESRC_W   = $clog2(NUM_GOE + 1)
) (
  input  logic                 rst_ni,
  input  logic [NUM_IOCLK-1:0] ioclk_i,
  input  logic [2:0]           cfg_mode_i,
  input  logic                 cfg_inv_i,
  input  logic [CLK_SEL_W-1:0] cfg_clk_sel_i,
  input  logic [OESRC_W-1:0]   cfg_oe_src_i,
  input  logic                 pad_in_i,
  output logic                 pad_out_o,
  output logic                 pad_oe_o,
  input  logic                 core_dout_i,
  input  logic                 core_oe_i,
  input  logic [NUM_GOE-1:0]   goe_i,
  output logic                 core_din_o
);
  pio_in_path #(.NUM_CLK(NUM_IOCLK), .CLK_SEL_W(CLK_SEL_W)) u_in (
    .rst_ni    (rst_ni),
    .ioclk_i   (ioclk_i),
    .clk_sel_i (cfg_clk_sel_i),
    .mode_i    (cfg_mode_i),
    .pad_in_i  (pad_in_i),
    .din_o     (core_din_o)
  );

  pio_out_path #(.NUM_GOE(NUM_GOE), .OESRC_W(OESRC_W)) u_out (
    .mode_i    (cfg_mode_i),
    .inv_i     (cfg_inv_i),
    .oe_src_i  (cfg_oe_src_i),
    .dout_i    (core_dout_i),
    .core_oe_i (core_oe_i),
    .goe_i     (goe_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );

  logic ext_src;
  assign ext_src = (cfg_oe_src_i != '0) && (int'(cfg_oe_src_i) <= int'(NUM_GOE));

  a_r5_input_modes_hiz: assert property (@(posedge ioclk_i[0]) disable iff (!rst_ni)
    !mode_drives(cfg_mode_i) |-> !pad_oe_o);

  a_r6_out_local_drives: assert property (@(posedge ioclk_i[0]) disable iff (!rst_ni)
    (cfg_mode_i == MODE_OUT && !ext_src) |-> pad_oe_o);

  a_r6_out_no_input: assert property (@(posedge ioclk_i[0]) disable iff (!rst_ni)
    (cfg_mode_i == MODE_OUT) |-> !core_din_o);

  a_r7_bidir_reads_pin: assert property (@(posedge ioclk_i[0]) disable iff (!rst_ni)
    (cfg_mode_i == MODE_BIDIR) |-> core_din_o == pad_in_i);

  a_r8_polarity: assert property (@(posedge ioclk_i[0]) disable iff (!rst_ni)
    cfg_inv_i |-> pad_out_o != core_dout_i);
endmodule

// File: tb/pio_cell_tb.sv
module pio_cell_tb;
  localparam int CLK_PERIOD = 10;

  logic       rst_n = 1'b0;
  logic [1:0] ioclk = 2'b10;
  logic [2:0] mode = 3'd1;
  logic       inv = 1'b0;
  logic       csel = 1'b0;
  logic [1:0] src = 2'd0;
  logic       pad = 1'b0;
  logic       dout = 1'b0;
  logic       coe = 1'b0;
  logic [1:0] goe = 2'b00;
  logic       pad_out, pad_oe, din;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) ioclk = ~ioclk;

  pio_cell u_dut (
    .rst_ni(rst_n), .ioclk_i(ioclk), .cfg_mode_i(mode), .cfg_inv_i(inv),
    .cfg_clk_sel_i(csel), .cfg_oe_src_i(src), .pad_in_i(pad),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .core_dout_i(dout),
    .core_oe_i(coe), .goe_i(goe), .core_din_o(din)
  );

  // reference storage, R2/R3/R10
  logic ref_reg0, ref_reg1, ref_lat0, ref_lat1;
  always @(posedge ioclk[0] or negedge rst_n) ref_reg0 <= rst_n ? pad : 1'b0;
  always @(posedge ioclk[1] or negedge rst_n) ref_reg1 <= rst_n ? pad : 1'b0;
  always @(ioclk[0] or rst_n or pad) if (!rst_n) ref_lat0 = 1'b0; else if (ioclk[0]) ref_lat0 = pad;
  always @(ioclk[1] or rst_n or pad) if (!rst_n) ref_lat1 = 1'b0; else if (ioclk[1]) ref_lat1 = pad;

  typedef struct {
    logic  din, out, oe;
    string rq_din, rq_out, rq_oe;
  } exp_t;

  exp_t exp_q[$];
  event sample_ev;

  task automatic check(string rq, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", rq, what, act, exp, $time);
    end
  endtask

  // monitor: pops expected items and compares with the design
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.rq_din, "core_din_o", din, e.din);
        check(e.rq_out, "pad_out_o", pad_out, e.out);
        check(e.rq_oe, "pad_oe_o", pad_oe, e.oe);
      end
    end
  end

  // driver: applies one vector and pushes its expected item
  task automatic drive(logic r, logic [2:0] m, logic iv, logic cs, logic [1:0] s,
                       logic p, logic d, logic ce, logic [1:0] g, string rq_over);
    exp_t e;
    logic sel_en, ext;
    @(posedge ioclk[0]);
    #2;
    rst_n = r; mode = m; inv = iv; csel = cs; src = s;
    pad = p; dout = d; coe = ce; goe = g;
    #1;
    case (m)
      3'd1: begin e.din = cs ? ref_reg1 : ref_reg0; e.rq_din = cs ? "R4" : "R2"; end
      3'd2: begin e.din = cs ? ref_lat1 : ref_lat0; e.rq_din = cs ? "R4" : "R3"; end
      3'd3: begin e.din = 1'b0; e.rq_din = "R6"; end
      3'd4: begin e.din = pad;  e.rq_din = "R7"; end
      3'd0: begin e.din = pad;  e.rq_din = "R1"; end
      default: begin e.din = pad; e.rq_din = "R5"; end
    endcase
    if (rq_over != "") e.rq_din = rq_over;
    e.out = d ^ iv;
    e.rq_out = "R8";
    ext    = (s == 2'd1) || (s == 2'd2);
    sel_en = (s == 2'd1) ? g[0] : (s == 2'd2) ? g[1] : ce;
    if (m == 3'd3) begin
      e.oe = ext ? sel_en : 1'b1; e.rq_oe = "R6";
    end else if (m == 3'd4) begin
      e.oe = sel_en; e.rq_oe = ext ? "R9" : "R7";
    end else begin
      e.oe = 1'b0; e.rq_oe = "R5";
    end
    exp_q.push_back(e);
    ->sample_ev;
  endtask

  initial begin
    // R10: storage held at 0 in reset while the pin is high
    drive(1'b0, 3'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'b00, "R10");
    drive(1'b0, 3'd2, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'b00, "R10");
    drive(1'b0, 3'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 2'b00, "R10");
    drive(1'b1, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'b00, "");

    for (int m = 0; m < 8; m++)
      for (int iv = 0; iv < 2; iv++)
        for (int cs = 0; cs < 2; cs++)
          for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
              drive(1'b1, 3'(m), 1'(iv), 1'(cs), 2'(s), p[0], p[1], p[0] ^ p[1],
                    {p[1] ^ 1'(s), p[0]}, "");

    // R10: reset asserted mid-run clears an open latch
    drive(1'b1, 3'd2, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'b00, "R3");
    drive(1'b0, 3'd2, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'b00, "R10");
    drive(1'b1, 3'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'b00, "R10");

    #(CLK_PERIOD);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard pending actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule